// File: doc/BRIEF.md
# JTAG Debug Register Access Port

This block is the target-side end of a JTAG link that lets an external debugger reach a bank of 32-bit debug registers and two 8-bit power registers. It contains the standard test access port state machine, a 5-bit instruction register and a set of data registers chosen by the current instruction. These are a one-bit bypass stage, a fixed 32-bit identification value, a power control byte, a power status byte and a register-select path.

A debug register is reached with two data scans under the register-select instruction. The first scan is 8 bits wide and names the register and the direction. The second scan is 32 bits wide and carries the data, either into the register or out of it. The debug registers sit behind a plain parallel register bus that is clocked by TCK. That bus has an address, a write strobe with write data, and a read strobe with read data that is sampled in the same cycle.

The power status byte collects event bits from its surroundings. A scan reads the byte out and clears the bits chosen by a mask in the same scan.

Top module: `dbg_tap_port`

## Requirements
- R1: An active-low `trst_n`, or five TCK rising edges with TMS high, puts the state machine in Test-Logic-Reset. There the instruction register loads 5'h1E, which selects the identification register. A 32-bit data scan then shifts out `ID_CODE` LSB first.
- R2: In Capture-IR the instruction shift register loads 5'b00001. An instruction scan therefore shifts out 1,0,0,0,0.
- R3: Opcode 5'h1F selects the 1-bit bypass register, which captures 0. Any opcode other than 08, 09, 1C and 1E also selects bypass. Through bypass, TDO repeats TDI one bit later.
- R4: Opcode 5'h08 selects the 8-bit power control register. The scan shifts out the current value, and Update-DR loads the shifted-in byte, which drives `pwr_ctrl`. The reset value is 0.
- R5: Opcode 5'h09 selects the 8-bit power status register. A bit goes to 1 and stays at 1 once `pwr_stat_set` has it high at a TCK rising edge. A scan shifts out the status. At Update-DR, every status bit whose shifted-in mask bit is 1 is cleared.
- R6: Under opcode 5'h1C, scans alternate between an address phase and a data phase. An address phase is 8 bits wide: bits [7:1] hold the register number and bit 0 is 1 for a write or 0 for a read. The data phase that follows is 32 bits wide. After a data phase the next scan is an address phase again.
- R7: A write data phase puts out a single-cycle `dbg_wr_stb` in the TCK cycle that follows Update-DR. During that strobe, `dbg_addr` holds the register number and `dbg_wdata` holds the 32 shifted-in bits.
- R8: In a read data phase, `dbg_rd_stb` is high during Capture-DR and `dbg_rdata` is captured at that edge. The captured word is then shifted out LSB first. The bits shifted in during the read are ignored and no write strobe occurs.
- R9: A register number above `MAX_REG` (default 95) is invalid. Such an access gives no write strobe and no read strobe, and a read of it shifts out zeros.
- R10: Loading any instruction at Update-IR, or entering Test-Logic-Reset, returns the register-select path to the address phase.
- R11: TDO changes only on the falling edge of TCK. It is 0 outside Shift-DR and Shift-IR.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| dbg_addr | output | ADDR_W | Register number of the current access |
| dbg_wdata | output | DATA_W | Write data, valid while the write strobe is high |
| dbg_wr_stb | output | 1 | One-cycle write strobe |
| dbg_rd_stb | output | 1 | Read strobe, high during Capture-DR of a read |
| dbg_rdata | input | DATA_W | Read data from the register bank |
| pwr_ctrl | output | PWR_W | Power control byte |
| pwr_stat_set | input | PWR_W | Event bits that set power status bits |

## Verification
Registers 95 and 96 are accessed to probe the edge of the valid range. An off-by-one limit would strobe register 96, or return the bus data for it instead of zeros. One check loads the instruction again halfway through an access. A phase flag that survives the new instruction would treat the next 8-bit scan as data and give a stray write. One read sends all-ones data into the scan; a design that let those bits through would put out a write strobe. The bypass and instruction-capture scans check the bit order and the one-bit delay. If TDO were launched on the wrong edge, every word read out would be shifted by one bit.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_PWRCTL  = 5'h08;
  localparam logic [IR_W-1:0] OP_PWRSTAT = 5'h09;
  localparam logic [IR_W-1:0] OP_REGSEL  = 5'h1C;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'h1E;
  localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [2:0] {
    PATH_BYP, PATH_ID, PATH_PCTL, PATH_PSTAT, PATH_REG
  } dr_path_e;

endpackage

// File: rtl/dbg_tap_rstsync.sv
module dbg_tap_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end

  // run length of TMS-high edges, saturating at five, for the reset check
  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)               tms_run <= 3'd0;
    else if (!tms)            tms_run <= 3'd0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  AST_FIVE_TMS_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run == 3'd5) |-> (state == ST_TLR)); // R1
endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
  import dbg_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_so
);
  logic [IR_W-1:0] sh_q, sh_d;
  logic            sh_en;
  logic [IR_W-1:0] ir_d;
  logic            ir_en;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    if (state == ST_CAP_IR) begin
      sh_en = 1'b1;
      sh_d  = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      sh_en = 1'b1;
      sh_d  = {tdi, sh_q[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir;
    if (state == ST_TLR) begin
      ir_en = 1'b1;
      ir_d  = OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ir_en = 1'b1;
      ir_d  = sh_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir <= OP_IDCODE;
    else if (ir_en) ir <= ir_d;
  end

  assign ir_so = sh_q[0];

  AST_TLR_LOADS_ID: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir == OP_IDCODE)); // R1
endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
  import dbg_tap_pkg::*;
#(
  parameter int                ADDR_W  = 7,
  parameter int                DATA_W  = 32,
  parameter int                PWR_W   = 8,
  parameter int                MAX_REG = 95,
  parameter logic [DATA_W-1:0] ID_CODE = 32'h3E5C_0B71
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  dr_path_e          path,
  input  logic              tdi,
  output logic              dr_so,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_wr_stb,
  output logic              dbg_rd_stb,
  input  logic [DATA_W-1:0] dbg_rdata,
  output logic [PWR_W-1:0]  pwr_ctrl,
  input  logic [PWR_W-1:0]  pwr_stat_set
);
  localparam int                ASCAN_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] MAX_A   = ADDR_W'(MAX_REG);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;
  logic              data_phase;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_wr;
  logic              acc_ok;
  logic [PWR_W-1:0]  pstat_q, pstat_d;
  logic              is_cap, is_sh, is_upd, is_reg;
  int                len;

  assign is_cap = (state == ST_CAP_DR);
  assign is_sh  = (state == ST_SH_DR);
  assign is_upd = (state == ST_UPD_DR);
  assign is_reg = (path == PATH_REG);
  assign acc_ok = (acc_addr <= MAX_A);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b, input int n);
    logic [DATA_W-1:0] r;
    r = v >> 1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i == n - 1)  r[i] = b;
      else if (i >= n) r[i] = 1'b0;
    end
    return r;
  endfunction

  // active scan length for the selected path and phase
  always_comb begin
    unique case (path)
      PATH_BYP:   len = 1;
      PATH_ID:    len = DATA_W;
      PATH_PCTL:  len = PWR_W;
      PATH_PSTAT: len = PWR_W;
      PATH_REG:   len = data_phase ? DATA_W : ASCAN_W;
      default:    len = 1;
    endcase
  end

  assign dbg_rd_stb = is_cap && is_reg && data_phase && !acc_wr && acc_ok;

  always_comb begin
    sh_en = 1'b0;
    sh_d  = sh_q;
    if (is_cap) begin
      sh_en = 1'b1;
      unique case (path)
        PATH_ID:    sh_d = ID_CODE;
        PATH_PCTL:  sh_d = {{(DATA_W-PWR_W){1'b0}}, pwr_ctrl};
        PATH_PSTAT: sh_d = {{(DATA_W-PWR_W){1'b0}}, pstat_q};
        PATH_REG:   sh_d = dbg_rd_stb ? dbg_rdata : '0;
        default:    sh_d = '0;
      endcase
    end else if (is_sh) begin
      sh_en = 1'b1;
      sh_d  = shift_in(sh_q, tdi, len);
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign dr_so = sh_q[0];

  // register-select phase and latched access
  logic phase_d, phase_en, acc_en, we_d, wd_en;

  always_comb begin
    phase_en = 1'b0;
    phase_d  = data_phase;
    if (state == ST_TLR || state == ST_UPD_IR) begin
      phase_en = 1'b1;
      phase_d  = 1'b0;
    end else if (is_upd && is_reg) begin
      phase_en = 1'b1;
      phase_d  = !data_phase;
    end
    acc_en = is_upd && is_reg && !data_phase;
    we_d   = is_upd && is_reg && data_phase && acc_wr && acc_ok;
    wd_en  = we_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        data_phase <= 1'b0;
    else if (phase_en) data_phase <= phase_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr <= '0;
      acc_wr   <= 1'b0;
    end else if (acc_en) begin
      acc_addr <= sh_q[ASCAN_W-1:1];
      acc_wr   <= sh_q[0];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     dbg_wr_stb <= 1'b0;
    else            dbg_wr_stb <= we_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     dbg_wdata <= '0;
    else if (wd_en) dbg_wdata <= sh_q;
  end

  assign dbg_addr = acc_addr;

  // power registers
  logic pctl_en, pclr;

  assign pctl_en = is_upd && (path == PATH_PCTL);
  assign pclr    = is_upd && (path == PATH_PSTAT);

  always_comb begin
    pstat_d = pstat_q;
    if (pclr) pstat_d = pstat_q & ~sh_q[PWR_W-1:0];
    pstat_d = pstat_d | pwr_stat_set;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       pwr_ctrl <= '0;
    else if (pctl_en) pwr_ctrl <= sh_q[PWR_W-1:0];
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) pstat_q <= '0;
    else        pstat_q <= pstat_d;
  end

  AST_WE_ONE_CYCLE: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_wr_stb |=> !dbg_wr_stb); // R7
  AST_WE_ADDR_STABLE: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_wr_stb |-> $stable(dbg_addr)); // R7
  AST_WE_IN_RANGE: assert property (@(posedge tck) disable iff (!rst_n)
    dbg_wr_stb |-> (dbg_addr <= MAX_A)); // R9
  AST_NO_RD_WITH_WE: assert property (@(posedge tck) disable iff (!rst_n)
    !(dbg_wr_stb && dbg_rd_stb)); // R8
  AST_PHASE_AFTER_IR: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_UPD_IR) |=> !data_phase); // R10
  AST_PSTAT_STICKY: assert property (@(posedge tck) disable iff (!rst_n)
    (pwr_stat_set != '0) |=> ((pstat_q & $past(pwr_stat_set)) == $past(pwr_stat_set))); // R5
endmodule

// File: rtl/dbg_tap_port.sv
module dbg_tap_port
  import dbg_tap_pkg::*;
#(
  parameter int                ADDR_W  = 7,
  parameter int                DATA_W  = 32,
  parameter int                PWR_W   = 8,
  parameter int                MAX_REG = 95,
  parameter logic [DATA_W-1:0] ID_CODE = 32'h3E5C_0B71
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_wdata,
  output logic              dbg_wr_stb,
  output logic              dbg_rd_stb,
  input  logic [DATA_W-1:0] dbg_rdata,
  output logic [PWR_W-1:0]  pwr_ctrl,
  input  logic [PWR_W-1:0]  pwr_stat_set
);
  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so, dr_so;
  dr_path_e        path;
  logic            tdo_d, tdo_q;

  dbg_tap_rstsync u_rst (.clk(tck), .arst_n(trst_n), .srst_n(rst_n));

  dbg_tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  dbg_tap_ir u_ir (.tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
                   .ir(ir), .ir_so(ir_so));

  always_comb begin
    unique case (ir)
      OP_IDCODE:  path = PATH_ID;
      OP_PWRCTL:  path = PATH_PCTL;
      OP_PWRSTAT: path = PATH_PSTAT;
      OP_REGSEL:  path = PATH_REG;
      default:    path = PATH_BYP;
    endcase
  end

  dbg_tap_dr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_W(PWR_W),
    .MAX_REG(MAX_REG), .ID_CODE(ID_CODE)
  ) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .path(path), .tdi(tdi),
    .dr_so(dr_so), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_wr_stb(dbg_wr_stb), .dbg_rd_stb(dbg_rd_stb), .dbg_rdata(dbg_rdata),
    .pwr_ctrl(pwr_ctrl), .pwr_stat_set(pwr_stat_set)
  );

  always_comb begin
    if (state == ST_SH_IR)      tdo_d = ir_so;
    else if (state == ST_SH_DR) tdo_d = dr_so;
    else                        tdo_d = 1'b0;
  end

  // launch on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo_q <= 1'b0;
    else        tdo_q <= tdo_d;
  end

  assign tdo = tdo_q;

  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
    !(state == ST_SH_DR || state == ST_SH_IR) |-> (tdo_q == 1'b0)); // R11
endmodule

// File: tb/tb_dbg_tap_port.sv
module tb_dbg_tap_port;
  localparam int          TCK_PERIOD = 20;
  localparam int          MAXR       = 95;
  localparam logic [31:0] EXP_ID     = 32'hC0DE_1235;

  logic        tck = 1'b0;
  logic        trst_n, tms, tdi, tdo;
  logic [6:0]  dbg_addr;
  logic [31:0] dbg_wdata, dbg_rdata;
  logic        dbg_wr_stb, dbg_rd_stb;
  logic [7:0]  pwr_ctrl, pwr_stat_set;

  int nchk = 0, nerr = 0;
  int we_cnt = 0, rd_cnt = 0;
  logic [6:0]  we_addr;
  logic [31:0] we_data;
  bit done = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  function automatic logic [31:0] mdl(input logic [6:0] a);
    return {a, 1'b0, 8'h3C, ~a, 1'b1, 8'hC3};
  endfunction

  assign dbg_rdata = mdl(dbg_addr);

  dbg_tap_port #(.MAX_REG(MAXR), .ID_CODE(EXP_ID)) dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_wr_stb(dbg_wr_stb),
    .dbg_rd_stb(dbg_rd_stb), .dbg_rdata(dbg_rdata),
    .pwr_ctrl(pwr_ctrl), .pwr_stat_set(pwr_stat_set)
  );

  always @(negedge tck) begin
    if (dbg_wr_stb) begin we_cnt++; we_addr = dbg_addr; we_data = dbg_wdata; end
    if (dbg_rd_stb) rd_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic so);
    @(negedge tck); #1;
    so = tdo; tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    logic b;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, b);
  endtask

  task automatic ir_scan(input logic [4:0] op, output logic [4:0] q);
    logic b;
    q = '0;
    step(1'b1, 1'b0, b); step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int i = 0; i < 5; i++) begin step(i == 4, op[i], b); q[i] = b; end
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
  endtask

  task automatic dr_scan(input int len, input logic [31:0] din, output logic [31:0] q);
    logic b;
    q = '0;
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b); step(1'b0, 1'b0, b);
    for (int i = 0; i < len; i++) begin step(i == len - 1, din[i], b); q[i] = b; end
    step(1'b1, 1'b0, b); step(1'b0, 1'b0, b);
  endtask

  // [39] write flag, [38:32] register number, [31:0] data
  localparam logic [39:0] VEC [10] = '{
    {1'b1, 7'd0,   32'hDEAD_BEEF},
    {1'b1, 7'd5,   32'h1234_5678},
    {1'b1, 7'd95,  32'h0000_0001},
    {1'b1, 7'd96,  32'hFFFF_0000},
    {1'b1, 7'd127, 32'hAAAA_5555},
    {1'b0, 7'd3,   32'h0},
    {1'b0, 7'd95,  32'h0},
    {1'b0, 7'd96,  32'h0},
    {1'b0, 7'd127, 32'h0},
    {1'b0, 7'd0,   32'h0}
  };

  initial begin
    logic [4:0]  q5;
    logic [31:0] q;
    logic        b;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pwr_stat_set = '0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
    // reset state
    chk(tdo == 1'b0, "R11 tdo low after reset", {31'd0, tdo}, 32'd0);
    chk(pwr_ctrl == 8'h00, "R4 pwr_ctrl reset", {24'd0, pwr_ctrl}, 32'd0);
    chk(dbg_wr_stb == 1'b0, "R7 no strobe at reset", {31'd0, dbg_wr_stb}, 32'd0);
    dr_scan(32, 32'h0, q);
    chk(q == EXP_ID, "R1 id after trst", q, EXP_ID);

    ir_scan(5'h1F, q5);
    chk(q5 == 5'b00001, "R2 capture-ir pattern", {27'd0, q5}, 32'd1);
    dr_scan(4, 32'hB, q);
    chk(q[3:0] == 4'b0110, "R3 bypass delay", q, 32'h6);
    ir_scan(5'h03, q5);
    dr_scan(4, 32'h5, q);
    chk(q[3:0] == 4'b1010, "R3 unknown opcode bypass", q, 32'hA);

    ir_scan(5'h08, q5);
    dr_scan(8, 32'hA5, q);
    chk(q[7:0] == 8'h00, "R4 pctl old value", q, 32'h0);
    idle(1);
    chk(pwr_ctrl == 8'hA5, "R4 pctl updated", {24'd0, pwr_ctrl}, 32'hA5);
    dr_scan(8, 32'h3C, q);
    chk(q[7:0] == 8'hA5, "R4 pctl readback", q, 32'hA5);

    pwr_stat_set = 8'h0F;
    idle(1);
    pwr_stat_set = 8'h00;
    ir_scan(5'h09, q5);
    dr_scan(8, 32'h05, q);
    chk(q[7:0] == 8'h0F, "R5 pstat sticky", q, 32'h0F);
    dr_scan(8, 32'h00, q);
    chk(q[7:0] == 8'h0A, "R5 pstat masked clear", q, 32'h0A);

    // table of register accesses
    foreach (VEC[k]) begin
      logic        wr;
      logic [6:0]  a;
      logic [31:0] d;
      bit          ok;
      wr = VEC[k][39]; a = VEC[k][38:32]; d = VEC[k][31:0];
      ok = (int'(a) <= MAXR);
      we_cnt = 0; rd_cnt = 0;
      ir_scan(5'h1C, q5);
      dr_scan(8, {24'd0, a, wr}, q);
      dr_scan(32, wr ? d : 32'hFFFF_FFFF, q);
      idle(2);
      if (wr) begin
        chk(we_cnt == (ok ? 1 : 0), ok ? "R7 write strobe count" : "R9 invalid write no strobe",
            we_cnt, ok ? 1 : 0);
        if (ok) begin
          chk(we_addr == a, "R7 write address", {25'd0, we_addr}, {25'd0, a});
          chk(we_data == d, "R7 write data", we_data, d);
        end
      end else begin
        chk(q == (ok ? mdl(a) : 32'h0), ok ? "R8 read data" : "R9 invalid read zero",
            q, ok ? mdl(a) : 32'h0);
        chk(rd_cnt == (ok ? 1 : 0), "R8 R9 read strobe count", rd_cnt, ok ? 1 : 0);
        chk(we_cnt == 0, "R8 read ignores tdi", we_cnt, 0);
      end
    end

    // new instruction mid-access resets the phase
    we_cnt = 0;
    ir_scan(5'h1C, q5);
    dr_scan(8, {24'd0, 7'd5, 1'b1}, q);
    ir_scan(5'h1C, q5);
    dr_scan(8, {24'd0, 7'd3, 1'b0}, q);
    dr_scan(32, 32'h0, q);
    idle(2);
    chk(we_cnt == 0, "R10 no stray write", we_cnt, 0);
    chk(q == mdl(7'd3), "R10 address phase after reload", q, mdl(7'd3));
    // phases keep alternating without a new instruction
    dr_scan(8, {24'd0, 7'd7, 1'b0}, q);
    dr_scan(32, 32'h0, q);
    chk(q == mdl(7'd7), "R6 second access same instruction", q, mdl(7'd7));

    // five TMS-high edges return to the id instruction
    ir_scan(5'h08, q5);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, b);
    step(1'b0, 1'b0, b);
    dr_scan(32, 32'h0, q);
    chk(q == EXP_ID, "R1 id after tms reset", q, EXP_ID);
    idle(2);
    chk(tdo == 1'b0, "R11 tdo low in idle", {31'd0, tdo}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(TCK_PERIOD * 50000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule